// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular list of transmit buffer descriptors kept in memory. Each descriptor occupies four 16-bit words at consecutive halfword addresses: a control word at offset 0, the byte count at offset 2, the upper half of the buffer address at offset 4 and the lower half at offset 6. The block reads these words through a simple 16-bit read port. It then offers the buffer to a downstream transmit path as one segment: start address, byte count, end-of-frame flag and two CRC controls, under a valid/ready handshake.

A single-cycle `poll` pulse wakes the block. It reads the descriptor at the current ring position. If the descriptor is ready, the block issues its segment, waits for the segment to be accepted, moves to the next position and reads the next descriptor. It keeps doing this until it finds a descriptor that is not ready. It then raises `ring_empty` for one cycle and goes idle. A descriptor whose buffer address is not word aligned raises `desc_err` for one cycle. Such a descriptor is never issued.

Control word bit assignments: bit 15 is ready, bit 13 is wrap, bit 11 is last-in-frame, bit 10 is append-CRC and bit 9 is corrupt-CRC. Bits 14, 12 and 8:0 are free for software or reserved.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset, no output strobe is active (`mem_req`, `seg_valid`, `ring_empty`, `desc_err` all 0), the block is idle and the ring position is cleared. The first descriptor read after reset is at `ring_base`.
- R2: After a `poll` in idle, the block reads the descriptor words in order at position+0, +2, +4 and +6. Each read is a one-cycle `mem_req`, and no new request is issued until `mem_rvalid` returns the previous word.
- R3: If bit 15 (ready) of the control word is 0, the block reads no further words of that descriptor and issues no segment. It pulses `ring_empty` for exactly one cycle and waits idle for the next `poll`. The ring position does not change, so the next poll reads the same descriptor again.
- R4: An issued segment carries `seg_addr` = {word at +4, word at +6} and `seg_len` = the word at +2, both unmodified.
- R5: While `seg_valid` is high and `seg_ready` is low, the segment and its fields stay stable, and the block neither reads memory nor advances the ring position.
- R6: After a segment is accepted, the next descriptor is at position+8 when bit 13 (wrap) is 0. When bit 13 is 1, the next descriptor is at `ring_base`.
- R7: `seg_last` equals bit 11 (last). When bit 11 is 0, `seg_crc` and `seg_crc_inv` are 0 whatever bits 10 and 9 hold.
- R8: When bit 11 is 1: `seg_crc` = bit 10 OR bit 9, and `seg_crc_inv` = bit 9. This means corrupt-CRC forces a CRC to be appended, inverted, even when append-CRC is 0.
- R9: A ready descriptor whose buffer address has bit 1 or bit 0 set is not issued. The block pulses `desc_err` for one cycle, returns to idle and keeps the ring position.
- R10: Control bits 14, 12 and 8:0 have no effect on any output or on the choice of the next descriptor.
- R11: After an accepted segment, the block goes on to read the next descriptor without a new `poll`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of the first descriptor of the ring |
| poll | input | 1 | One-cycle strobe that starts a descriptor check |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Byte address of the halfword being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| seg_valid | output | 1 | Segment offered to the transmit path |
| seg_ready | input | 1 | Transmit path accepts the segment |
| seg_addr | output | 32 | Buffer start address |
| seg_len | output | 16 | Buffer byte count |
| seg_last | output | 1 | Segment ends the frame |
| seg_crc | output | 1 | Append a CRC after this segment |
| seg_crc_inv | output | 1 | The appended CRC is sent inverted |
| ring_empty | output | 1 | One-cycle pulse: a not-ready descriptor was found |
| desc_err | output | 1 | One-cycle pulse: a misaligned buffer address was found |

## Verification
The bench goes after the points where a walker most easily loses its place in the ring:
- A design that advanced on a not-ready or misaligned descriptor would skip that descriptor on the next poll. The bench therefore re-polls and checks the address of the repeated read.
- A wrap bit ignored or misread would send the fetch past the ring's end instead of back to `ring_base`.
- Back-pressure held for several cycles would expose a design that drops `seg_valid` or starts the next fetch before acceptance.
- The bench also feeds CRC controls on a non-final buffer, corrupt-CRC with append-CRC clear, and control words full of don't-care bits. A decoder that leaked those bits into the segment flags, or into the next-descriptor choice, would show up in the captured segments.

// File: rtl/txd_ring_walker.sv
module txd_ring_walker #(
  parameter int ADDR_W      = 32,
  parameter int DESC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              poll,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [31:0]       seg_addr,
  output logic [15:0]       seg_len,
  output logic              seg_last,
  output logic              seg_crc,
  output logic              seg_crc_inv,
  output logic              ring_empty,
  output logic              desc_err
);

  localparam int B_RDY  = 15;
  localparam int B_WRAP = 13;
  localparam int B_LAST = 11;
  localparam int B_CRC  = 10;
  localparam int B_BAD  = 9;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_ISSUE} state_t;

  state_t            st;
  logic [1:0]        wcnt;
  logic [ADDR_W-1:0] off;
  logic [15:0]       ctrl_q, len_q, hi_q, lo_q;
  logic              empty_q, err_q;
  logic              accept;

  assign accept      = (st == S_ISSUE) && seg_ready;
  assign mem_req     = (st == S_REQ);
  assign mem_addr    = ring_base + off + ADDR_W'({wcnt, 1'b0});
  assign seg_valid   = (st == S_ISSUE);
  assign seg_addr    = {hi_q, lo_q};
  assign seg_len     = len_q;
  assign seg_last    = ctrl_q[B_LAST];
  assign seg_crc     = ctrl_q[B_LAST] & (ctrl_q[B_CRC] | ctrl_q[B_BAD]);
  assign seg_crc_inv = ctrl_q[B_LAST] & ctrl_q[B_BAD];
  assign ring_empty  = empty_q;
  assign desc_err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wcnt    <= '0;
      off     <= '0;
      ctrl_q  <= '0;
      len_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      empty_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      empty_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (st)
        S_IDLE: if (poll) begin
          wcnt <= '0;
          st   <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          unique case (wcnt)
            2'd0: begin
              ctrl_q <= mem_rdata;
              if (!mem_rdata[B_RDY]) begin
                empty_q <= 1'b1;
                st      <= S_IDLE;
              end else begin
                wcnt <= 2'd1;
                st   <= S_REQ;
              end
            end
            2'd1: begin len_q <= mem_rdata; wcnt <= 2'd2; st <= S_REQ; end
            2'd2: begin hi_q  <= mem_rdata; wcnt <= 2'd3; st <= S_REQ; end
            default: begin
              lo_q <= mem_rdata;
              if (|mem_rdata[1:0]) begin
                err_q <= 1'b1;
                st    <= S_IDLE;
              end else begin
                st <= S_ISSUE;
              end
            end
          endcase
        end
        S_ISSUE: if (seg_ready) begin
          off  <= ctrl_q[B_WRAP] ? '0 : off + ADDR_W'(DESC_STRIDE);
          wcnt <= '0;
          st   <= S_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R2
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last)); // R5
  AST_NO_FETCH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !mem_req); // R5
  AST_POS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(off)); // R6
  AST_EMPTY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ring_empty |=> !ring_empty && !seg_valid); // R3
  AST_ALIGNED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> seg_addr[1:0] == 2'b00); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |=> !desc_err && !seg_valid); // R9
  AST_CRC_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_last |-> !seg_crc && !seg_crc_inv); // R7
  AST_INV_NEEDS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    seg_crc_inv |-> seg_crc); // R8

endmodule

// File: tb/txd_ring_walker_tb.sv
module txd_ring_walker_tb;
  localparam logic [31:0] BASE = 32'h40;
  localparam logic [15:0] F_R = 16'h8000, F_W = 16'h2000, F_L = 16'h0800,
                          F_TC = 16'h0400, F_ABC = 16'h0200, F_JUNK = 16'h51FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll = 1'b0;
  logic seg_ready = 1'b1;
  logic mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic mem_req, seg_valid, seg_last, seg_crc, seg_crc_inv, ring_empty, desc_err;
  logic [31:0] mem_addr, seg_addr;
  logic [15:0] seg_len;

  always #2 clk = ~clk;

  txd_ring_walker u_dut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE), .poll(poll),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_last(seg_last), .seg_crc(seg_crc), .seg_crc_inv(seg_crc_inv),
    .ring_empty(ring_empty), .desc_err(desc_err)
  );

  logic [15:0] mem [0:63];
  logic        busy = 1'b0;
  logic [1:0]  lat = '0;
  logic [31:0] paddr = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (busy) begin
      if (lat == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[paddr[6:1]];
        busy       <= 1'b0;
      end else lat <= lat - 1'b1;
    end
    if (mem_req) begin
      busy  <= 1'b1;
      lat   <= 2'd1;
      paddr <= mem_addr;
    end
  end

  int segn = 0, emptyn = 0, errn = 0, reqn = 0;
  logic [31:0] s_addr [0:31];
  logic [15:0] s_len  [0:31];
  logic [2:0]  s_fl   [0:31];
  logic [31:0] reqlog [0:255];

  always @(negedge clk) begin
    if (rst_n) begin
      if (seg_valid && seg_ready) begin
        s_addr[segn[4:0]] <= seg_addr;
        s_len[segn[4:0]]  <= seg_len;
        s_fl[segn[4:0]]   <= {seg_last, seg_crc, seg_crc_inv};
        segn <= segn + 1;
      end
      if (mem_req) begin
        reqlog[reqn[7:0]] <= mem_addr;
        reqn <= reqn + 1;
      end
      if (ring_empty) emptyn <= emptyn + 1;
      if (desc_err) errn <= errn + 1;
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wdesc(input int idx, input logic [15:0] st, input logic [15:0] len, input logic [31:0] ptr);
    int w;
    w = int'(BASE[6:1]) + idx * 4;
    mem[w]   = st;
    mem[w+1] = len;
    mem[w+2] = ptr[31:16];
    mem[w+3] = ptr[15:0];
  endtask

  task automatic do_reset();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    @(negedge clk);
    rst_n = 1'b0; poll = 1'b0; seg_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic wait_stop(input int e0, input int x0);
    int n;
    n = 0;
    while (emptyn == e0 && errn == x0 && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk("timeout", 1, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mem_req", mem_req, 0);
    chk("R1 seg_valid", seg_valid, 0);
    chk("R1 ring_empty", ring_empty, 0);
    chk("R1 desc_err", desc_err, 0);
  endtask

  task automatic t_empty();
    int s0, e0, r0;
    do_reset();
    s0 = segn; e0 = emptyn; r0 = reqn;
    do_poll(); wait_stop(e0, errn);
    chk("R3 empty pulse count", emptyn - e0, 1);
    chk("R3 no segment", segn - s0, 0);
    chk("R3 only control read", reqn - r0, 1);
    chk("R1 first read at base", reqlog[r0[7:0]], BASE);
    repeat (5) @(negedge clk);
    chk("R3 idle without poll", reqn - r0, 1);
    r0 = reqn; e0 = emptyn;
    do_poll(); wait_stop(e0, errn);
    chk("R3 same descriptor reread", reqlog[r0[7:0]], BASE);
  endtask

  task automatic t_frame();
    int s0, e0, r0;
    do_reset();
    wdesc(0, F_R, 16'd100, 32'h0001_1000);
    wdesc(1, F_R | F_L | F_TC, 16'd60, 32'hABCD_2004);
    s0 = segn; e0 = emptyn; r0 = reqn;
    do_poll(); wait_stop(e0, errn);
    chk("R11 two segments", segn - s0, 2);
    chk("R4 seg0 addr", s_addr[s0[4:0]], 32'h0001_1000);
    chk("R4 seg0 len", s_len[s0[4:0]], 100);
    chk("R7 seg0 flags", s_fl[s0[4:0]], 3'b000);
    chk("R4 seg1 addr", s_addr[s0[4:0]+1], 32'hABCD_2004);
    chk("R4 seg1 len", s_len[s0[4:0]+1], 60);
    chk("R8 seg1 flags TC", s_fl[s0[4:0]+1], 3'b110);
    chk("R2 read count", reqn - r0, 9);
    for (int k = 0; k < 4; k++)
      chk("R2 word order", reqlog[r0[7:0]+k[7:0]], BASE + 32'(2*k));
    chk("R6 next consecutive", reqlog[r0[7:0]+4], BASE + 8);
    chk("R6 third descriptor", reqlog[r0[7:0]+8], BASE + 16);
    chk("R3 empty at end", emptyn - e0, 1);
  endtask

  task automatic t_wrap();
    int s0, e0, r0, n;
    do_reset();
    wdesc(0, F_R | F_L, 16'd10, 32'h0000_0100);
    wdesc(1, F_R | F_W | F_L | F_ABC, 16'd20, 32'h0000_0208);
    wdesc(2, F_R | F_L, 16'd30, 32'h0000_0300);
    s0 = segn; e0 = emptyn; r0 = reqn;
    do_poll();
    n = 0;
    while (segn == s0 && n < 500) begin @(negedge clk); n++; end
    mem[int'(BASE[6:1])] = 16'h0000;
    wait_stop(e0, errn);
    chk("R6 two segments before wrap", segn - s0, 2);
    chk("R8 ABC without TC", s_fl[s0[4:0]+1], 3'b111);
    chk("R7 last no crc", s_fl[s0[4:0]], 3'b100);
    chk("R6 wrapped to base", reqlog[reqn[7:0]-1], BASE);
    chk("R6 read count", reqn - r0, 9);
    do_reset();
    wdesc(0, 16'h0000, 16'd1, 32'h0);
    r0 = reqn; e0 = emptyn;
    do_poll(); wait_stop(e0, errn);
    chk("R1 position cleared by reset", reqlog[r0[7:0]], BASE);
  endtask

  task automatic t_stall();
    int e0, r0, n;
    logic held;
    do_reset();
    wdesc(0, F_R | F_L | F_TC, 16'd5, 32'h0000_0300);
    e0 = emptyn;
    seg_ready = 1'b0;
    do_poll();
    n = 0;
    while (!seg_valid && n < 500) begin @(negedge clk); n++; end
    r0 = reqn; held = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (!seg_valid || seg_addr !== 32'h300) held = 1'b0;
    end
    chk("R5 segment held", held, 1);
    chk("R5 no read while stalled", reqn - r0, 0);
    seg_ready = 1'b1;
    wait_stop(e0, errn);
    chk("R5 advance after accept", reqlog[reqn[7:0]-1], BASE + 8);
  endtask

  task automatic t_misalign();
    int s0, e0, x0, r0;
    do_reset();
    wdesc(0, F_R | F_L, 16'd7, 32'h0000_0402);
    s0 = segn; x0 = errn; e0 = emptyn;
    do_poll(); wait_stop(e0, x0);
    chk("R9 error bit1", errn - x0, 1);
    chk("R9 not issued", segn - s0, 0);
    wdesc(0, F_R | F_L, 16'd7, 32'h0000_0401);
    x0 = errn; r0 = reqn;
    do_poll(); wait_stop(e0, x0);
    chk("R9 error bit0", errn - x0, 1);
    chk("R9 position kept", reqlog[r0[7:0]], BASE);
    chk("R9 no empty pulse", emptyn - e0, 0);
    wdesc(0, F_R | F_L, 16'd7, 32'h0000_0400);
    x0 = errn; e0 = emptyn;
    do_poll(); wait_stop(e0, x0);
    chk("R9 fixed descriptor issued", s_addr[s0[4:0]], 32'h400);
  endtask

  task automatic t_ignore();
    int s0, e0, r0;
    do_reset();
    wdesc(0, F_R | F_L | F_TC | F_JUNK, 16'd33, 32'h0000_0500);
    wdesc(1, F_R | F_TC | F_ABC | F_JUNK, 16'd44, 32'h0000_0504);
    wdesc(2, F_R | F_L, 16'd55, 32'h0000_0508);
    s0 = segn; e0 = emptyn; r0 = reqn;
    do_poll(); wait_stop(e0, errn);
    chk("R10 junk bits segment count", segn - s0, 3);
    chk("R10 junk bits flags", s_fl[s0[4:0]], 3'b110);
    chk("R7 crc masked when not last", s_fl[s0[4:0]+1], 3'b000);
    chk("R7 last only", s_fl[s0[4:0]+2], 3'b100);
    chk("R10 no wrap from junk", reqlog[r0[7:0]+4], BASE + 8);
  endtask

  initial begin
    t_reset();
    t_empty();
    t_frame();
    t_wrap();
    t_stall();
    t_misalign();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule